// File: doc/BRIEF.md
# Clock Divider and Doze Controller

This block holds one software-visible clock control word and runs the strobe dividers that the word selects. Everything works on a single fast clock. Each output is an enable pulse rather than a gated clock. The outputs are:

- an oscillator-rate tick, taken from a postscaler;
- a system tick, taken from a power-of-two select;
- a CPU tick, which fires on one system tick in every 2^k while doze is active.

Peripherals keep running at the system rate, and the CPU slows relative to them. The CPU tick therefore always lands on a system tick.

Software writes the whole control word through a plain write strobe and reads it back at any time. An interrupt-event input can cancel doze automatically when the recover bit is set. While the USB-enabled status input is high, the system-rate select is frozen, but the other fields still accept writes.

Control word layout (bit positions):

| Bits | Field |
|------|-------|
| 1:0 | system select |
| 4:2 | oscillator postscaler |
| 7:5 | doze code |
| 8 | doze enable |
| 9 | recover-on-interrupt |
| 10 | reserved |
| 15:11 | unimplemented |

Top module: `clkdiv_ctl`

## Requirements
- R1: While reset is held and right after it, the readback equals 0x0004: postscaler code 001, and system select, doze code, doze enable and recover all 0.
- R2: Postscaler codes 0 to 6 give one `osc_tick` per 2^code fast-clock cycles.
- R3: Postscaler code 7 gives one `osc_tick` per 256 cycles, not 128.
- R4: System select code c (bits 1:0) gives one `sys_tick` per 2^c cycles.
- R5: With doze enable 1, `cpu_tick` fires on one of every 2^d system ticks, where d is the doze code (bits 7:5). With doze enable 0, `cpu_tick` equals `sys_tick`. `cpu_tick` is never high without `sys_tick`.
- R6: When recover is 1, a high `irq_evt` clears doze enable at the next edge, and the CPU rate returns to 1:1.
- R7: When recover is 0, `irq_evt` leaves doze enable unchanged.
- R8: A write that sets doze enable, made in the same cycle as an interrupt while recover is 1, leaves doze enable 0.
- R9: While `usb_on` is high, a write leaves the system select unchanged and updates every other field.
- R10: Bit 10 (reserved) and bits 15:11 read 0 whatever was written. Writing 0xFFFF reads back 0x03FF.
- R11: In the cycle after a divider's ratio changes, that divider emits no tick, then counts from zero. With a ratio of N > 1, the first tick comes N+1 cycles after the write cycle.
- R12: At divide-by-1 a tick output is high on every cycle it advances.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast oscillator clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 16 | Control word to write |
| rd_data | output | 16 | Control word readback |
| irq_evt | input | 1 | Interrupt event, one cycle per event |
| usb_on | input | 1 | USB enabled, freezes the system select |
| osc_tick | output | 1 | Postscaled oscillator enable |
| sys_tick | output | 1 | System rate enable |
| cpu_tick | output | 1 | CPU rate enable, a subset of sys_tick |

## Verification
The hardest case to reach is the one where an interrupt and a doze-enabling write land in the same cycle. The case only matters when recover is already set and doze is still off before that edge. The stimulus reaches it in two steps. First it writes recover=1 with doze disabled. Then it issues a second write, which sets doze enable, together with a one-cycle `irq_evt`. Doze at the largest ratio on the slowest system select is also hard to reach, because a CPU tick there is 1024 cycles apart. The bench writes 0xFFFF and runs past two full CPU periods, so that the nested counter's restart and wrap are both compared cycle by cycle against the reference model.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

    // Control word fields, most significant first; bit 0 is sys_code[0].
    typedef struct packed {
        logic       recover;
        logic       doze_on;
        logic [2:0] doze_code;
        logic [2:0] osc_code;
        logic [1:0] sys_code;
    } ctl_t;

    localparam int CTL_W          = $bits(ctl_t);
    localparam int OSC_MAX_SHIFT  = 8;
    localparam int CNT_W          = OSC_MAX_SHIFT;
    localparam int SHIFT_W        = $clog2(OSC_MAX_SHIFT + 1);

    localparam ctl_t CTL_RESET = '{
        recover:   1'b0,
        doze_on:   1'b0,
        doze_code: 3'd0,
        osc_code:  3'd1,
        sys_code:  2'd0
    };

    // Postscaler: codes follow powers of two except the top code.
    function automatic logic [SHIFT_W-1:0] osc_shift(input logic [2:0] code);
        if (code == 3'd7) return SHIFT_W'(OSC_MAX_SHIFT);
        return SHIFT_W'(code);
    endfunction

endpackage

// File: rtl/clkdiv_regs.sv
module clkdiv_regs
    import clkdiv_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              usb_on,
    input  logic              irq_evt,
    output ctl_t              ctl_q,
    output logic [DATA_W-1:0] rd_data
);

    localparam int PAD_W = DATA_W - CTL_W;

    ctl_t ctl_d;
    logic unused_hi;

    assign unused_hi = ^wr_data[DATA_W-1:CTL_W];

    always_comb begin
        ctl_d = ctl_q;
        if (wr_en) begin
            ctl_d = ctl_t'(wr_data[CTL_W-1:0]);
            if (usb_on) begin
                ctl_d.sys_code = ctl_q.sys_code;
            end
        end
        // Interrupt recovery takes priority over a same-cycle write.
        if (irq_evt && ctl_q.recover) begin
            ctl_d.doze_on = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= CTL_RESET;
        else        ctl_q <= ctl_d;
    end

    assign rd_data = {{PAD_W{1'b0}}, ctl_q};

    p_usb_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && usb_on) |=> (ctl_q.sys_code == $past(ctl_q.sys_code)));

    p_irq_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_evt && ctl_q.recover) |=> !ctl_q.doze_on);

    p_irq_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_evt && !ctl_q.recover && !wr_en) |=> $stable(ctl_q.doze_on));

endmodule

// File: rtl/clkdiv_tick.sv
module clkdiv_tick #(
    parameter int CNT_W     = 8,
    parameter int SHW       = 4,
    parameter int RST_SHIFT = 0
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           adv,
    input  logic [SHW-1:0] shift,
    output logic           tick
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [SHW-1:0]   last;
    } st_t;

    st_t st_d, st_q;
    logic [CNT_W:0]   full;
    logic [CNT_W-1:0] mask;
    logic             chg;

    always_comb begin
        full = (CNT_W+1)'(1) << shift;
        mask = CNT_W'(full - 1'b1);
        chg  = (shift != st_q.last);
        tick = adv && ((shift == '0) || (!chg && (st_q.cnt == mask)));

        st_d      = st_q;
        st_d.last = shift;
        if (chg) begin
            st_d.cnt = '0;
        end else if (adv) begin
            st_d.cnt = tick ? '0 : st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt  <= '0;
            st_q.last <= SHW'(RST_SHIFT);
        end else begin
            st_q <= st_d;
        end
    end

    // Above divide-by-1, two ticks never fall in adjacent cycles.
    p_tick_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && shift != '0) |=> (!tick || shift == '0));

endmodule

// File: rtl/clkdiv_ctl.sv
module clkdiv_ctl
    import clkdiv_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    input  logic              irq_evt,
    input  logic              usb_on,
    output logic              osc_tick,
    output logic              sys_tick,
    output logic              cpu_tick
);

    ctl_t             ctl;
    logic [SHIFT_W-1:0] osc_sh, sys_sh, doze_sh;
    logic             doze_tick;

    clkdiv_regs #(.DATA_W(DATA_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .usb_on  (usb_on),
        .irq_evt (irq_evt),
        .ctl_q   (ctl),
        .rd_data (rd_data)
    );

    always_comb begin
        osc_sh  = osc_shift(ctl.osc_code);
        sys_sh  = SHIFT_W'(ctl.sys_code);
        doze_sh = ctl.doze_on ? SHIFT_W'(ctl.doze_code) : '0;
    end

    clkdiv_tick #(.CNT_W(CNT_W), .SHW(SHIFT_W), .RST_SHIFT(1)) u_osc (
        .clk (clk), .rst_n (rst_n), .adv (1'b1), .shift (osc_sh), .tick (osc_tick)
    );

    clkdiv_tick #(.CNT_W(CNT_W), .SHW(SHIFT_W), .RST_SHIFT(0)) u_sys (
        .clk (clk), .rst_n (rst_n), .adv (1'b1), .shift (sys_sh), .tick (sys_tick)
    );

    // Doze counter advances on system ticks only.
    clkdiv_tick #(.CNT_W(CNT_W), .SHW(SHIFT_W), .RST_SHIFT(0)) u_doze (
        .clk (clk), .rst_n (rst_n), .adv (sys_tick), .shift (doze_sh), .tick (doze_tick)
    );

    assign cpu_tick = sys_tick & doze_tick;

    p_cpu_in_sys_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_tick |-> sys_tick);

    p_sys_div1_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[1:0] == 2'd0) |-> sys_tick);

endmodule

// File: tb/sim_clkdiv_ctl.sv
module sim_clkdiv_ctl;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic        irq_evt = 1'b0;
    logic        usb_on = 1'b0;
    logic        osc_tick, sys_tick, cpu_tick;

    int checks = 0;
    int errors = 0;
    string rd_tag = "R1";

    // Reference state
    int m_sys = 0, m_osc = 1, m_dz = 0, m_don = 0, m_rcv = 0;
    int o_cnt = 0, o_prev = 1;
    int s_cnt = 0, s_prev = 0;
    int d_cnt = 0, d_prev = 0;
    bit last_osc;

    always #(CLK_PERIOD/2) clk = ~clk;

    clkdiv_ctl u0 (
        .clk (clk), .rst_n (rst_n), .wr_en (wr_en), .wr_data (wr_data),
        .rd_data (rd_data), .irq_evt (irq_evt), .usb_on (usb_on),
        .osc_tick (osc_tick), .sys_tick (sys_tick), .cpu_tick (cpu_tick)
    );

    function automatic int word(int rcv, int don, int dz, int osc, int sys);
        return (rcv << 9) | (don << 8) | (dz << 5) | (osc << 2) | sys;
    endfunction

    function automatic bit exp_tick(int cnt, int prev, int sh, bit adv);
        return adv && (sh == 0 || (sh == prev && cnt == (1 << sh) - 1));
    endfunction

    function automatic void next_cnt(ref int cnt, ref int prev, input int sh,
                                     input bit adv, input bit t);
        if (sh != prev) cnt = 0;
        else if (adv) cnt = t ? 0 : cnt + 1;
        prev = sh;
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic step(input bit w, input int d, input bit irq, input bit usb);
        int osh, ssh, dsh, exp_rd;
        bit eo, es, ed, ec, old_rcv;
        string otag, stag;
        wr_en = w; wr_data = 16'(d); irq_evt = irq; usb_on = usb;
        #1;
        osh = (m_osc == 7) ? 8 : m_osc;
        ssh = m_sys;
        dsh = m_don ? m_dz : 0;
        eo = exp_tick(o_cnt, o_prev, osh, 1'b1);
        es = exp_tick(s_cnt, s_prev, ssh, 1'b1);
        ed = exp_tick(d_cnt, d_prev, dsh, es);
        ec = es && ed;
        exp_rd = word(m_rcv, m_don, m_dz, m_osc, m_sys);
        otag = (m_osc == 7) ? "R3" : ((osh == 0) ? "R12" : "R2");
        stag = (ssh == 0) ? "R12" : "R4";
        check(osc_tick == eo, otag, "osc_tick", osc_tick, eo);
        check(sys_tick == es, stag, "sys_tick", sys_tick, es);
        check(cpu_tick == ec, "R5", "cpu_tick", cpu_tick, ec);
        check(rd_data == 16'(exp_rd), rd_tag, "rd_data", rd_data, exp_rd);
        last_osc = osc_tick;
        @(posedge clk);
        next_cnt(o_cnt, o_prev, osh, 1'b1, eo);
        next_cnt(s_cnt, s_prev, ssh, 1'b1, es);
        next_cnt(d_cnt, d_prev, dsh, es, ed);
        old_rcv = (m_rcv != 0);
        if (w) begin
            m_osc = (d >> 2) & 7; m_dz = (d >> 5) & 7;
            m_don = (d >> 8) & 1; m_rcv = (d >> 9) & 1;
            if (!usb) m_sys = d & 3;
        end
        if (irq && old_rcv) m_don = 0;
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 0, 1'b0, 1'b0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int n;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(rd_data == 16'h0004, "R1", "reset readback", rd_data, 16'h0004);
        rst_n = 1'b1;
        rd_tag = "R1";
        idle(6);

        // Postscaler sweep, every code including the irregular top one
        rd_tag = "R2";
        for (int c = 0; c < 8; c++) begin
            step(1'b1, word(0, 0, 0, c, 0), 1'b0, 1'b0);
            idle(((c == 7) ? 256 : (1 << c)) * 2 + 4);
        end

        // Restart timing after a ratio change (N=8 -> first tick 9 steps later)
        rd_tag = "R11";
        step(1'b1, word(0, 0, 0, 3, 0), 1'b0, 1'b0);
        n = 0;
        for (int i = 1; i <= 20; i++) begin
            step(1'b0, 0, 1'b0, 1'b0);
            if (last_osc && n == 0) n = i;
        end
        check(n == 9, "R11", "cycles to first osc tick", n, 9);

        // System select sweep
        rd_tag = "R4";
        for (int c = 0; c < 4; c++) begin
            step(1'b1, word(0, 0, 0, 1, c), 1'b0, 1'b0);
            idle((1 << c) * 3 + 3);
        end

        // Doze 1:4 on system divide-by-2, then 1:1 with doze off
        rd_tag = "R5";
        step(1'b1, word(0, 1, 2, 1, 1), 1'b0, 1'b0);
        idle(40);
        step(1'b1, word(0, 0, 5, 1, 1), 1'b0, 1'b0);
        idle(12);

        // Recover on interrupt
        rd_tag = "R6";
        step(1'b1, word(1, 1, 3, 1, 0), 1'b0, 1'b0);
        idle(20);
        step(1'b0, 0, 1'b1, 1'b0);
        check(rd_data[8] == 1'b0, "R6", "doze enable after irq", rd_data[8], 0);
        idle(10);

        // Interrupt with recover off
        rd_tag = "R7";
        step(1'b1, word(0, 1, 1, 1, 0), 1'b0, 1'b0);
        idle(4);
        step(1'b0, 0, 1'b1, 1'b0);
        check(rd_data[8] == 1'b1, "R7", "doze enable kept", rd_data[8], 1);
        idle(6);

        // Same-cycle interrupt and doze-enabling write
        rd_tag = "R8";
        step(1'b1, word(1, 0, 2, 1, 0), 1'b0, 1'b0);
        step(1'b1, word(1, 1, 2, 1, 0), 1'b1, 1'b0);
        check(rd_data[8] == 1'b0, "R8", "irq beats write", rd_data[8], 0);
        idle(6);

        // USB freezes the system select only
        rd_tag = "R9";
        step(1'b1, word(0, 0, 0, 2, 1), 1'b0, 1'b0);
        step(1'b1, word(0, 0, 0, 4, 3), 1'b0, 1'b1);
        check(rd_data[1:0] == 2'd1, "R9", "sys select frozen", rd_data[1:0], 1);
        check(rd_data[4:2] == 3'd4, "R9", "osc code updated", rd_data[4:2], 4);
        idle(20);

        // All ones: reserved and unimplemented bits read zero; deepest doze
        rd_tag = "R10";
        step(1'b1, 16'hFFFF, 1'b0, 1'b0);
        check(rd_data == 16'h03FF, "R10", "all-ones readback", rd_data, 16'h03FF);
        idle(2100);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule